// File: doc/BRIEF.md
# Triggered DAC Sample Front End with Wave Synthesis

This block is the digital side of a single-channel 12-bit converter. Software or a DMA engine writes a sample into a holding register through a small register bus. The sample can be written in any of three formats. The block then moves that sample into the output code register. The move happens either one clock after the write, or on a trigger chosen from four timer pulses, one external event line and a software strobe.

On a triggered move the block can add generated wave content to the held sample, with the sum saturated at full scale. The content is either pseudo-random noise from a 12-bit shift register or a rising and falling triangle ramp. A width field limits both kinds: it masks the noise bits or sets the triangle peak.

Each triggered move can also raise a DMA request for the next sample. A sticky underrun flag records a move that arrives while the previous request is still unanswered. The flag can drive an interrupt. One control bit is passed straight out to bypass the analog output driver.

Top module: `dac_wave_ctrl`

## Requirements
- R1: After reset the output code is 0, `dma_req`, `irq` and `buf_bypass` are 0, and the control word reads back as 0.
- R2: Word address 2 takes `bus_wdata[11:0]` as the sample. Address 3 takes `bus_wdata[15:4]`. Address 4 takes `bus_wdata[7:0]` into code bits [11:4] and clears code bits [3:0].
- R3: The control word is at address 0, with bit 0 = converter enable and bit 1 = trigger enable. With the converter enabled and triggers disabled, the output code takes the written sample on the clock edge after the write edge, with no wave content added.
- R4: With trigger enable set, a sample write alone does not change the output. Trigger select is control bits [4:2]: codes 0 to 3 pick `tmr_trig[0..3]`, code 4 picks `ext_trig`, code 7 picks the software strobe, and codes 5 and 6 pick nothing. A pulse on the selected input, sampled at edge E, updates the output at edge E+1. Pulses on inputs that are not selected have no effect.
- R5: Writing 1 to bit 0 of address 1 makes a one-cycle software strobe. With code 7 selected, the output updates on the second edge after the write edge.
- R6: With the converter enable at 0, neither sample writes nor triggers change the output code, and no DMA request is raised.
- R7: Wave mode is control bits [6:5]: 0 = none, 1 = noise, 2 = triangle, 3 = none. In noise mode each triggered move outputs the saturated sum of the held sample and (noise state AND mask). The noise state starts at 0xA5F and then steps after each move as state = {state[10:0], state[11]^state[5]^state[3]^state[0]}.
- R8: In triangle mode each triggered move outputs the saturated sum of the held sample and a counter. The counter starts at 0 counting up. After each move it steps by one, turns down on reaching the peak, and turns up on reaching 0.
- R9: The width field is control bits [10:7] and holds n-1, where values of 11 or more mean n = 12. The mask and the triangle peak are both 2^n-1. A sum above 4095 gives 4095.
- R10: DMA enable is control bit 11. When it is set, each triggered move raises `dma_req`. `dma_ack` lowers it.
- R11: A triggered move while `dma_req` is still high and `dma_ack` is low sets the underrun flag, which reads as bit 0 of address 6. Writing 1 to that bit clears the flag.
- R12: Underrun interrupt enable is control bit 12. `irq` is high exactly when the underrun flag and that enable are both set.
- R13: Control bit 13 drives `buf_bypass`. Address 5 reads back the current output code in bits [11:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| tmr_trig | input | 4 | Timer trigger pulses |
| ext_trig | input | 1 | External event trigger pulse |
| dma_req | output | 1 | Request for the next sample |
| dma_ack | input | 1 | Acknowledge of the request |
| irq | output | 1 | Underrun interrupt |
| buf_bypass | output | 1 | Output driver bypass control |
| out_code | output | 12 | Current converter code |

## Verification
Each result has its own latency:
- A sample write in direct mode appears on `out_code` one edge after the write edge.
- A hardware trigger sampled at edge E appears at E+1.
- A software strobe written at edge E appears at E+2.
- `dma_req` and the underrun flag change on the same edge as the triggered move.

Inputs are driven on the falling edge, and every check samples on a falling edge. A latency is confirmed by checking that the old value is still present one edge early and that the new value appears on the edge that is due. The bench keeps its own model of the noise register and triangle counter, stepping it once per triggered move to predict every code.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  localparam int CODE_W  = 12;
  localparam int BUS_W   = 16;
  localparam int ADDR_W  = 4;
  localparam int NARROW_W = 8;
  localparam int TSEL_W  = 3;
  localparam int WIDTH_W = 4;
  localparam int N_TMR   = 4;
  localparam logic [CODE_W-1:0] LFSR_SEED = 12'hA5F;
  localparam logic [CODE_W-1:0] LFSR_TAPS = 12'h829;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_SWTRIG = 4'd1;
  localparam logic [ADDR_W-1:0] A_RIGHT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_LEFT   = 4'd3;
  localparam logic [ADDR_W-1:0] A_NARROW = 4'd4;
  localparam logic [ADDR_W-1:0] A_OUT    = 4'd5;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd6;

  typedef enum logic [1:0] {
    WAVE_NONE  = 2'd0,
    WAVE_NOISE = 2'd1,
    WAVE_TRI   = 2'd2,
    WAVE_RSVD  = 2'd3
  } wave_e;

  typedef struct packed {
    logic               buf_off;
    logic               urun_ie;
    logic               dma_en;
    logic [WIDTH_W-1:0] width_m1;
    wave_e              mode;
    logic [TSEL_W-1:0]  tsel;
    logic               trig_en;
    logic               conv_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic [CODE_W-1:0] width_mask(input logic [WIDTH_W-1:0] f);
    logic [CODE_W-1:0] m;
    for (int i = 0; i < CODE_W; i++) m[i] = (i <= int'(f));
    return m;
  endfunction

  function automatic logic [CODE_W-1:0] sat_add(input logic [CODE_W-1:0] a,
                                                input logic [CODE_W-1:0] b);
    logic [CODE_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CODE_W] ? '1 : s[CODE_W-1:0];
  endfunction

  function automatic logic [CODE_W-1:0] lfsr_step(input logic [CODE_W-1:0] s);
    return {s[CODE_W-2:0], ^(s & LFSR_TAPS)};
  endfunction
endpackage

// File: rtl/dwc_regs.sv
module dwc_regs
  import dwc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [CODE_W-1:0] out_code,
  input  logic              urun_flag,
  output ctrl_t             ctrl,
  output logic [CODE_W-1:0] hold,
  output logic              hold_wr,
  output logic              sw_pend,
  output logic              stat_clr
);
  localparam int PAD_W = CODE_W - NARROW_W;

  logic wr_ctrl, wr_sw, wr_right, wr_left, wr_narrow;

  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign wr_sw     = bus_wr && (bus_addr == A_SWTRIG) && bus_wdata[0];
  assign wr_right  = bus_wr && (bus_addr == A_RIGHT);
  assign wr_left   = bus_wr && (bus_addr == A_LEFT);
  assign wr_narrow = bus_wr && (bus_addr == A_NARROW);
  assign hold_wr   = wr_right || wr_left || wr_narrow;
  assign stat_clr  = bus_wr && (bus_addr == A_STAT) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      hold    <= '0;
      sw_pend <= 1'b0;
    end else begin
      sw_pend <= wr_sw;
      if (wr_ctrl)   ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_right)  hold <= bus_wdata[CODE_W-1:0];
      if (wr_left)   hold <= bus_wdata[BUS_W-1 -: CODE_W];
      if (wr_narrow) hold <= {bus_wdata[NARROW_W-1:0], {PAD_W{1'b0}}};
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl;
      A_RIGHT: bus_rdata[CODE_W-1:0] = hold;
      A_OUT:   bus_rdata[CODE_W-1:0] = out_code;
      A_STAT:  bus_rdata[0]          = urun_flag;
      default: bus_rdata             = '0;
    endcase
  end

  AST_SW_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_pend && !wr_sw) |=> !sw_pend);  // R5
  AST_NARROW_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_narrow |=> (hold[PAD_W-1:0] == '0));  // R2
endmodule

// File: rtl/dwc_trig.sv
module dwc_trig
  import dwc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TMR-1:0]  tmr_trig,
  input  logic              ext_trig,
  input  logic              sw_pend,
  input  logic [TSEL_W-1:0] tsel,
  input  logic              trig_en,
  input  logic              conv_en,
  output logic              fire_q
);
  localparam int N_SRC = 1 << TSEL_W;

  logic [N_SRC-1:0] src;
  logic             fire;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (i < N_TMR) begin : g_tmr
      assign src[i] = tmr_trig[i];
    end else if (i == N_TMR) begin : g_ext
      assign src[i] = ext_trig;
    end else if (i == N_SRC - 1) begin : g_sw
      assign src[i] = sw_pend;
    end else begin : g_none
      assign src[i] = 1'b0;
    end
  end

  assign fire = conv_en && trig_en && src[tsel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_q <= 1'b0;
    else        fire_q <= fire;
  end

  AST_NO_FIRE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_en || !trig_en) |=> !fire_q);  // R6
endmodule

// File: rtl/dwc_wave.sv
module dwc_wave
  import dwc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  wave_e              mode,
  input  logic [WIDTH_W-1:0] width_m1,
  input  logic [CODE_W-1:0]  hold,
  output logic [CODE_W-1:0]  wave_code
);
  logic [CODE_W-1:0] lfsr_q, tri_q, mask;
  logic              up_q, step_noise, step_tri;

  assign mask       = width_mask(width_m1);
  assign step_noise = step && (mode == WAVE_NOISE);
  assign step_tri   = step && (mode == WAVE_TRI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= LFSR_SEED;
      tri_q  <= '0;
      up_q   <= 1'b1;
    end else begin
      if (step_noise) lfsr_q <= lfsr_step(lfsr_q);
      if (step_tri) begin
        if (up_q) begin
          if (tri_q >= mask) begin
            up_q  <= 1'b0;
            tri_q <= tri_q - 1'b1;
          end else begin
            tri_q <= tri_q + 1'b1;
          end
        end else if (tri_q == '0) begin
          up_q  <= 1'b1;
          tri_q <= tri_q + 1'b1;
        end else begin
          tri_q <= tri_q - 1'b1;
        end
      end
    end
  end

  always_comb begin
    unique case (mode)
      WAVE_NOISE: wave_code = sat_add(hold, lfsr_q & mask);
      WAVE_TRI:   wave_code = sat_add(hold, tri_q);
      default:    wave_code = hold;
    endcase
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);  // R7
  AST_TRI_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_tri |=> ((tri_q == $past(tri_q) + 12'd1) || (tri_q == $past(tri_q) - 12'd1)));  // R8
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wave_code >= hold);  // R9
endmodule

// File: rtl/dwc_dma.sv
module dwc_dma (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer,
  input  logic dma_en,
  input  logic dma_ack,
  input  logic stat_clr,
  input  logic urun_ie,
  output logic dma_req,
  output logic urun_flag,
  output logic irq
);
  logic underrun;

  assign underrun = xfer && dma_en && dma_req && !dma_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_req   <= 1'b0;
      urun_flag <= 1'b0;
    end else begin
      if (!dma_en)      dma_req <= 1'b0;
      else if (xfer)    dma_req <= 1'b1;
      else if (dma_ack) dma_req <= 1'b0;
      if (underrun)      urun_flag <= 1'b1;
      else if (stat_clr) urun_flag <= 1'b0;
    end
  end

  assign irq = urun_flag && urun_ie;

  AST_REQ_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && dma_en) |=> dma_req);  // R10
  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && !xfer) |=> !dma_req);  // R10
  AST_UNDERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && dma_en && dma_req && !dma_ack) |=> urun_flag);  // R11
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (urun_flag && !stat_clr) |=> urun_flag);  // R11
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !urun_ie |-> !irq);  // R12
endmodule

// File: rtl/dac_wave_ctrl.sv
module dac_wave_ctrl
  import dwc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [N_TMR-1:0]  tmr_trig,
  input  logic              ext_trig,
  output logic              dma_req,
  input  logic              dma_ack,
  output logic              irq,
  output logic              buf_bypass,
  output logic [CODE_W-1:0] out_code
);
  ctrl_t             ctrl;
  logic [CODE_W-1:0] hold, wave_code;
  logic              hold_wr, sw_pend, stat_clr, urun_flag, xfer, copy_pend;

  dwc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .out_code(out_code),
    .urun_flag(urun_flag), .ctrl(ctrl), .hold(hold), .hold_wr(hold_wr),
    .sw_pend(sw_pend), .stat_clr(stat_clr)
  );

  dwc_trig u_trig (
    .clk(clk), .rst_n(rst_n), .tmr_trig(tmr_trig), .ext_trig(ext_trig),
    .sw_pend(sw_pend), .tsel(ctrl.tsel), .trig_en(ctrl.trig_en),
    .conv_en(ctrl.conv_en), .fire_q(xfer)
  );

  dwc_wave u_wave (
    .clk(clk), .rst_n(rst_n), .step(xfer), .mode(ctrl.mode),
    .width_m1(ctrl.width_m1), .hold(hold), .wave_code(wave_code)
  );

  dwc_dma u_dma (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .dma_en(ctrl.dma_en),
    .dma_ack(dma_ack), .stat_clr(stat_clr), .urun_ie(ctrl.urun_ie),
    .dma_req(dma_req), .urun_flag(urun_flag), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      copy_pend <= 1'b0;
      out_code  <= '0;
    end else begin
      copy_pend <= hold_wr && ctrl.conv_en && !ctrl.trig_en;
      if (xfer)           out_code <= wave_code;
      else if (copy_pend) out_code <= hold;
    end
  end

  assign buf_bypass = ctrl.buf_off;

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !copy_pend) |=> $stable(out_code));  // R4
  AST_DISABLED_NO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_wr && !ctrl.conv_en) |=> !copy_pend);  // R6
endmodule

// File: tb/dac_wave_ctrl_bench.sv
`timescale 1ns/1ps
module dac_wave_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_rdata;
  logic [3:0]  tmr_trig = '0;
  logic        ext_trig = 1'b0;
  logic        dma_req, dma_ack = 1'b0, irq, buf_bypass;
  logic [11:0] out_code;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dac_wave_ctrl u_dac_wave_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .tmr_trig(tmr_trig),
    .ext_trig(ext_trig), .dma_req(dma_req), .dma_ack(dma_ack), .irq(irq),
    .buf_bypass(buf_bypass), .out_code(out_code)
  );

  function automatic logic [15:0] mk_ctrl(input int conv, input int trig, input int sel,
                                          input int mode, input int wid, input int dma,
                                          input int ie, input int boff);
    return 16'(conv | (trig << 1) | (sel << 2) | (mode << 5) | (wid << 7) |
               (dma << 11) | (ie << 12) | (boff << 13));
  endfunction

  function automatic logic [11:0] m_next(input logic [11:0] s);
    logic b;
    b = s[11] ^ s[5] ^ s[3] ^ s[0];
    return (s << 1) | 12'(b);
  endfunction

  function automatic logic [11:0] m_sat(input int a, input int b);
    return (a + b > 4095) ? 12'd4095 : 12'(a + b);
  endfunction

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [3:0] t, input logic e);
    tmr_trig = t; ext_trig = e;
    tick;
    tmr_trig = '0; ext_trig = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] r;
    chk("R1 out", 16'(out_code), 16'h0);
    chk("R1 req", 16'(dma_req), 16'h0);
    chk("R1 irq", 16'(irq), 16'h0);
    chk("R1 bypass", 16'(buf_bypass), 16'h0);
    rd(4'd0, r);
    chk("R1 ctrl", r, 16'h0);
  endtask

  task automatic t_direct;
    logic [15:0] r;
    wr(4'd0, mk_ctrl(1, 0, 0, 1, 11, 0, 0, 0));
    wr(4'd2, 16'hF123);
    chk("R3 not yet", 16'(out_code), 16'h0);
    tick;
    chk("R3 R2 right", 16'(out_code), 16'h123);
    wr(4'd3, 16'hABC7);
    tick;
    chk("R2 left", 16'(out_code), 16'hABC);
    wr(4'd4, 16'h335A);
    tick;
    chk("R2 narrow", 16'(out_code), 16'h5A0);
    rd(4'd5, r);
    chk("R13 readback", r, 16'h05A0);
  endtask

  task automatic t_disabled;
    wr(4'd0, mk_ctrl(0, 1, 0, 0, 0, 1, 0, 0));
    wr(4'd2, 16'h777);
    tick;
    chk("R6 write ignored", 16'(out_code), 16'h5A0);
    pulse(4'b0001, 1'b0);
    tick;
    chk("R6 trigger ignored", 16'(out_code), 16'h5A0);
    chk("R6 no req", 16'(dma_req), 16'h0);
  endtask

  task automatic t_select;
    wr(4'd0, mk_ctrl(1, 1, 2, 0, 0, 0, 0, 0));
    wr(4'd2, 16'h400);
    tick;
    chk("R4 write waits", 16'(out_code), 16'h5A0);
    pulse(4'b1011, 1'b1);
    tick;
    chk("R4 unselected", 16'(out_code), 16'h5A0);
    pulse(4'b0100, 1'b0);
    chk("R4 latency", 16'(out_code), 16'h5A0);
    tick;
    chk("R4 timer2", 16'(out_code), 16'h400);
    wr(4'd0, mk_ctrl(1, 1, 4, 0, 0, 0, 0, 0));
    wr(4'd2, 16'h401);
    pulse(4'b0000, 1'b1);
    tick;
    chk("R4 ext", 16'(out_code), 16'h401);
    wr(4'd0, mk_ctrl(1, 1, 5, 0, 0, 0, 0, 0));
    wr(4'd2, 16'h402);
    pulse(4'b1111, 1'b1);
    tick;
    chk("R4 code5 none", 16'(out_code), 16'h401);
  endtask

  task automatic t_soft;
    wr(4'd0, mk_ctrl(1, 1, 7, 0, 0, 0, 0, 0));
    wr(4'd2, 16'h321);
    wr(4'd1, 16'h0001);
    chk("R5 edge0", 16'(out_code), 16'h401);
    tick;
    chk("R5 edge1", 16'(out_code), 16'h401);
    tick;
    chk("R5 edge2", 16'(out_code), 16'h321);
  endtask

  task automatic t_noise;
    logic [11:0] s = 12'hA5F;
    wr(4'd0, mk_ctrl(1, 1, 0, 1, 3, 0, 0, 0));
    wr(4'd2, 16'h100);
    for (int i = 0; i < 6; i++) begin
      pulse(4'b0001, 1'b0);
      tick;
      chk("R7 noise", 16'(out_code), 16'(m_sat(256, int'(s & 12'h00F))));
      s = m_next(s);
    end
    wr(4'd0, mk_ctrl(1, 1, 0, 1, 15, 0, 0, 0));
    wr(4'd2, 16'hFF0);
    for (int i = 0; i < 4; i++) begin
      pulse(4'b0001, 1'b0);
      tick;
      chk("R9 full width sat", 16'(out_code), 16'(m_sat(4080, int'(s))));
      s = m_next(s);
    end
  endtask

  task automatic t_tri;
    int c = 0;
    int up = 1;
    wr(4'd0, mk_ctrl(1, 1, 0, 2, 1, 0, 0, 0));
    wr(4'd2, 16'h010);
    for (int i = 0; i < 9; i++) begin
      pulse(4'b0001, 1'b0);
      tick;
      chk("R8 R9 triangle", 16'(out_code), 16'(16 + c));
      if (up == 1) begin
        if (c >= 3) begin up = 0; c--; end else c++;
      end else begin
        if (c == 0) begin up = 1; c++; end else c--;
      end
    end
  endtask

  task automatic t_dma;
    logic [15:0] r;
    wr(4'd0, mk_ctrl(1, 1, 0, 0, 0, 1, 1, 1));
    chk("R13 bypass", 16'(buf_bypass), 16'h1);
    pulse(4'b0001, 1'b0);
    tick;
    chk("R10 req up", 16'(dma_req), 16'h1);
    dma_ack = 1'b1;
    tick;
    dma_ack = 1'b0;
    chk("R10 ack drops", 16'(dma_req), 16'h0);
    pulse(4'b0001, 1'b0);
    tick;
    chk("R11 no flag yet", 16'(irq), 16'h0);
    pulse(4'b0001, 1'b0);
    tick;
    rd(4'd6, r);
    chk("R11 flag set", r, 16'h1);
    chk("R12 irq", 16'(irq), 16'h1);
    wr(4'd0, mk_ctrl(1, 1, 0, 0, 0, 1, 0, 1));
    chk("R12 masked", 16'(irq), 16'h0);
    wr(4'd0, mk_ctrl(1, 1, 0, 0, 0, 1, 1, 1));
    wr(4'd6, 16'h0001);
    rd(4'd6, r);
    chk("R11 cleared", r, 16'h0);
    chk("R12 irq off", 16'(irq), 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_direct;
    t_disabled;
    t_select;
    t_soft;
    t_noise;
    t_tri;
    t_dma;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule